// File: doc/BRIEF.md
# Serial Memory Command Interface

This block is the slave side of a three-wire serial memory port, clocked by a fast system clock that samples the chip-select, serial-clock and serial-data-in lines. When chip select goes high, it waits for a start bit. It then shifts in a four-bit opcode, an address and, for the write-type commands, a data field. It decodes seven commands. The storage is a small register array of 256 bits. A mode input presents that array either as sixteen 16-bit words or as thirty-two bytes.

Reads stream out on the serial data output. The block also keeps a write-enable latch. The array changes when a write-type command is accepted, and the same command goes to an external programming controller as a one-cycle request. That request carries the command kind, the address and the data. While the controller is busy, the data output reports busy or ready whenever chip select is high.

Top module: `mw_cmd_if`

## Requirements
- R1: After chip select rises, rising serial-clock edges that sample data-in low do not advance the decoder. The first edge that samples a 1 is taken as the start bit.
- R2: The four opcode bits follow the start bit, first bit received as the MSB. Read is 10xx, write is 01xx and erase is 11xx. Enable is 0011, disable is 0000, erase-all is 0010 and write-all is 0001.
- R3: The address after the opcode is 4 bits when `org`=1 (word mode) and 5 bits when `org`=0 (byte mode). It is sent MSB first. In byte mode, byte address a selects word a>>1, and bit 0 = 0 selects bits 15:8 of that word.
- R4: On a read, the serial-clock rising edge that samples the last address bit puts a 0 on `sdo`. Each later rising edge presents the next data bit, MSB first, 16 bits per word in word mode and 8 per byte in byte mode.
- R5: While chip select stays high, the bit after the last bit of a unit is the MSB of the unit at the next address, with no 0 between them. The address wraps from the top address (15 in word mode, 31 in byte mode) to 0.
- R6: The write-enable latch is clear after reset. Enable sets it and disable clears it. While it is clear, write, erase, erase-all and write-all issue no request and leave the array unchanged. Reads work whatever the latch holds.
- R7: A write-type command takes effect only when chip select falls after the full command has been shifted in. If chip select falls earlier, the command has no effect.
- R8: An accepted command pulses `prog_req` for one cycle. `prog_kind` is 0 for write, 1 for erase, 2 for write-all and 3 for erase-all. `prog_addr` holds the received address and `prog_data` holds the received data, right-aligned.
- R9: Write replaces the addressed unit and erase sets it to all ones. Erase-all sets every bit to 1. Write-all ANDs the data into every unit, with the byte repeated in both halves of each word in byte mode.
- R10: After an accepted command, while chip select is high and before a start bit arrives, `sdo_oe`=1 and `sdo` = NOT `prog_busy`. A 1 on data-in while `prog_busy` is high is not taken as a start bit.
- R11: After reset the array holds all ones. `sdo_oe` is 0 whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, high while a command is active |
| sclk | input | 1 | Serial clock; its rising edges sample `sdi` and advance `sdo` |
| sdi | input | 1 | Serial data in |
| org | input | 1 | 1 = word mode, 0 = byte mode |
| prog_busy | input | 1 | High while the programming controller is working |
| sdo | output | 1 | Serial data out (read data or ready/busy status) |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means high impedance |
| prog_req | output | 1 | One-cycle request for an accepted write-type command |
| prog_kind | output | 2 | Kind of command requested |
| prog_addr | output | 5 | Address of the request (byte or word address) |
| prog_data | output | 16 | Data of the request |

## Verification
The bench builds the block with its default parameters: 16-bit words and 16 words. With these values the array holds 256 bits, so byte mode has 5 address bits and word mode has 4. Both the word-mode and byte-mode wrap points can be reached in two or three streamed units. The bench writes bytes into both halves of one word and reads that word back in word mode, which pins down the byte order. Write-all following erase-all, in both modes, shows the AND of two patterns.

// File: rtl/mw_pkg.sv
// Shared types for the serial memory command interface.
// Assumes: nothing beyond IEEE 1800-2017.
package mw_pkg;

    // Decoder states of the serial front end.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_DONE
    } mw_state_e;

    // Kinds of programming requests handed to the controller.
    typedef enum logic [1:0] {
        PK_WRITE = 2'd0,
        PK_ERASE = 2'd1,
        PK_WRAL  = 2'd2,
        PK_ERAL  = 2'd3
    } prog_kind_e;

endpackage

// File: rtl/mw_frontend.sv
// Serial command decoder. It detects rising serial-clock edges, hunts for
// the start bit, shifts in the opcode, address and data, and keeps the
// write-enable latch. At chip-select fall it issues one-cycle programming
// requests. Assumes the serial lines are already synchronous to clk and
// that the serial clock is much slower than clk.
module mw_frontend
    import mw_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              org,
    input  logic              prog_busy,
    output logic              rd_load,
    output logic              rd_shift,
    output logic [AW:0]       rd_addr,
    output logic              reading,
    output logic              status_on,
    output logic              prog_req,
    output prog_kind_e        prog_kind,
    output logic [AW:0]       prog_addr,
    output logic [WORD_W-1:0] prog_data
);
    localparam int BW = WORD_W / 2;
    localparam int CW = $clog2(WORD_W) + 1;

    mw_state_e         state_q;
    logic              cs_q, sclk_q;
    logic [CW-1:0]     cnt_q;
    logic [3:0]        opc_q;
    logic [AW:0]       addr_q;
    logic [WORD_W-1:0] data_q;
    logic              wel_q, status_q;

    logic              rise, fall, exec_now;
    logic [CW-1:0]     alast, dlast;
    logic              is_prog, set_wel, clr_wel, need_data;
    prog_kind_e        kind_sel;

    // Edge detection and field lengths for the selected organisation.
    always_comb begin
        rise     = cs & sclk & ~sclk_q;
        fall     = ~cs & cs_q;
        exec_now = fall && (state_q == ST_DONE);
        alast    = org ? CW'(AW - 1) : CW'(AW);
        dlast    = org ? CW'(WORD_W - 1) : CW'(BW - 1);
    end

    // Opcode decode into actions taken at chip-select fall.
    always_comb begin
        is_prog   = 1'b0;
        set_wel   = 1'b0;
        clr_wel   = 1'b0;
        kind_sel  = PK_WRITE;
        need_data = (opc_q[3:2] == 2'b01) || (opc_q == 4'b0001);
        case (opc_q[3:2])
            2'b01: begin is_prog = 1'b1; kind_sel = PK_WRITE; end
            2'b11: begin is_prog = 1'b1; kind_sel = PK_ERASE; end
            2'b00: begin
                case (opc_q[1:0])
                    2'b11: set_wel = 1'b1;
                    2'b00: clr_wel = 1'b1;
                    2'b10: begin is_prog = 1'b1; kind_sel = PK_ERAL; end
                    default: begin is_prog = 1'b1; kind_sel = PK_WRAL; end
                endcase
            end
            default: ;
        endcase
    end

    // Strobes toward the read shifter and status toward the output pin.
    assign rd_load   = rise && (state_q == ST_ADDR) && (cnt_q == alast) && (opc_q[3:2] == 2'b10);
    assign rd_addr   = {addr_q[AW-1:0], sdi};
    assign rd_shift  = rise && (state_q == ST_READ);
    assign reading   = (state_q == ST_READ);
    assign status_on = status_q && (state_q == ST_HUNT);

    // Decoder state machine, write-enable latch and request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cs_q      <= 1'b0;
            sclk_q    <= 1'b0;
            cnt_q     <= '0;
            opc_q     <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            wel_q     <= 1'b0;
            status_q  <= 1'b0;
            prog_req  <= 1'b0;
            prog_kind <= PK_WRITE;
            prog_addr <= '0;
            prog_data <= '0;
        end else begin
            cs_q     <= cs;
            sclk_q   <= sclk;
            prog_req <= 1'b0;
            if (!cs) begin
                state_q <= ST_IDLE;
                if (exec_now) begin
                    if (set_wel) wel_q <= 1'b1;
                    if (clr_wel) wel_q <= 1'b0;
                    if (is_prog && wel_q) begin
                        prog_req  <= 1'b1;
                        prog_kind <= kind_sel;
                        prog_addr <= addr_q;
                        prog_data <= data_q;
                        status_q  <= 1'b1;
                    end
                end
            end else begin
                case (state_q)
                    ST_IDLE: state_q <= ST_HUNT;
                    ST_HUNT: begin
                        if (rise && sdi && !prog_busy) begin
                            state_q  <= ST_OPC;
                            cnt_q    <= '0;
                            status_q <= 1'b0;
                        end
                    end
                    ST_OPC: begin
                        if (rise) begin
                            opc_q <= {opc_q[2:0], sdi};
                            if (cnt_q == CW'(3)) begin
                                state_q <= ST_ADDR;
                                cnt_q   <= '0;
                                addr_q  <= '0;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_ADDR: begin
                        if (rise) begin
                            addr_q <= {addr_q[AW-1:0], sdi};
                            if (cnt_q == alast) begin
                                cnt_q  <= '0;
                                data_q <= '0;
                                if (opc_q[3:2] == 2'b10) state_q <= ST_READ;
                                else if (need_data)      state_q <= ST_DATA;
                                else                     state_q <= ST_DONE;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_DATA: begin
                        if (rise) begin
                            data_q <= {data_q[WORD_W-2:0], sdi};
                            if (cnt_q == dlast) state_q <= ST_DONE;
                            else                cnt_q   <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_REQ_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> wel_q); // R6
    AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req); // R8
    AST_START_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPC && $past(state_q) != ST_OPC) |-> ($past(state_q) == ST_HUNT && $past(sdi))); // R1
    AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT && prog_busy) |=> state_q != ST_OPC); // R10

endmodule

// File: rtl/mw_array.sv
// Register array of WORDS x WORD_W bits. It can be viewed as words or
// as bytes, where an even byte address is the high byte of its word.
// Applies write, erase, erase-all and write-all on a one-cycle exec
// strobe. Assumes exec comes only from the decoder's accepted requests.
module mw_array
    import mw_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int WORDS  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       org,
    input  logic                       exec,
    input  prog_kind_e                 kind,
    input  logic [$clog2(WORDS):0]     addr,
    input  logic [WORD_W-1:0]          wdata,
    input  logic [$clog2(WORDS):0]     rd_addr,
    output logic [WORD_W-1:0]          rd_unit
);
    localparam int AW = $clog2(WORDS);
    localparam int BW = WORD_W / 2;

    logic [WORD_W-1:0] mem [WORDS];
    logic [WORD_W-1:0] nxt [WORDS];
    logic [WORD_W-1:0] wral_pat;
    logic [WORDS-1:0]  word_full;
    logic [WORD_W-1:0] rd_word;

    // Next value of every word for the pending request.
    always_comb begin
        wral_pat = org ? wdata : {wdata[BW-1:0], wdata[BW-1:0]};
        for (int i = 0; i < WORDS; i++) begin
            logic hit;
            hit    = org ? (addr[AW-1:0] == AW'(i)) : (addr[AW:1] == AW'(i));
            nxt[i] = mem[i];
            case (kind)
                PK_WRITE: if (hit) begin
                    if (org)          nxt[i] = wdata;
                    else if (!addr[0]) nxt[i][WORD_W-1:BW] = wdata[BW-1:0];
                    else              nxt[i][BW-1:0] = wdata[BW-1:0];
                end
                PK_ERASE: if (hit) begin
                    if (org)          nxt[i] = '1;
                    else if (!addr[0]) nxt[i][WORD_W-1:BW] = '1;
                    else              nxt[i][BW-1:0] = '1;
                end
                PK_ERAL: nxt[i] = '1;
                default: nxt[i] = mem[i] & wral_pat;
            endcase
        end
    end

    // Storage: all ones at reset, updated on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (exec) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= nxt[i];
        end
    end

    // Read view: a whole word, or one byte right-aligned.
    always_comb begin
        rd_word = org ? mem[rd_addr[AW-1:0]] : mem[rd_addr[AW:1]];
        if (org)            rd_unit = rd_word;
        else if (rd_addr[0]) rd_unit = {{BW{1'b0}}, rd_word[BW-1:0]};
        else                rd_unit = {{BW{1'b0}}, rd_word[WORD_W-1:BW]};
    end

    // Per-word all-ones flags for the erase-all check.
    for (genvar g = 0; g < WORDS; g++) begin : g_full
        assign word_full[g] = &mem[g];
    end

    AST_ERAL_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && kind == PK_ERAL) |=> (&word_full)); // R9

endmodule

// File: rtl/mw_read_shift.sv
// Read output sequencer. It loads the start address with a dummy zero
// on sdo, then presents one bit of the current unit per shift strobe,
// MSB first, and steps the address with wrap at the end of each unit.
// Assumes the array does not change while a read streams.
module mw_read_shift #(
    parameter int WORD_W = 16,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              org,
    input  logic              load,
    input  logic [AW:0]       load_addr,
    input  logic              shift,
    input  logic [WORD_W-1:0] rd_unit,
    output logic [AW:0]       ptr,
    output logic              sdo_bit
);
    localparam int BW = WORD_W / 2;
    localparam int CW = $clog2(WORD_W);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] ulast;
    logic [AW:0]   ptr_inc;

    // Unit length and wrapped next address for the organisation.
    always_comb begin
        ulast   = org ? CW'(WORD_W - 1) : CW'(BW - 1);
        ptr_inc = org ? {1'b0, ptr[AW-1:0] + 1'b1} : ptr + 1'b1;
    end

    // Bit position, address pointer and output bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ptr     <= '0;
            sdo_bit <= 1'b0;
        end else if (load) begin
            cnt_q   <= '0;
            ptr     <= load_addr;
            sdo_bit <= 1'b0;
        end else if (shift) begin
            sdo_bit <= rd_unit[ulast - cnt_q];
            if (cnt_q == ulast) begin
                cnt_q <= '0;
                ptr   <= ptr_inc;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !sdo_bit); // R4
    AST_WORD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load && org && cnt_q == ulast && ptr[AW-1:0] == '1) |=> ptr == '0); // R5

endmodule

// File: rtl/mw_cmd_if.sv
// Top of the serial memory command interface. It joins the decoder, the
// read sequencer and the storage array, and muxes read data and
// ready/busy status onto the serial output. Assumes prog_busy comes from
// the external programming controller fed by prog_req.
module mw_cmd_if
    import mw_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int WORDS  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs,
    input  logic                   sclk,
    input  logic                   sdi,
    input  logic                   org,
    input  logic                   prog_busy,
    output logic                   sdo,
    output logic                   sdo_oe,
    output logic                   prog_req,
    output logic [1:0]             prog_kind,
    output logic [$clog2(WORDS):0] prog_addr,
    output logic [WORD_W-1:0]      prog_data
);
    localparam int AW = $clog2(WORDS);

    logic              rd_load, rd_shift, reading, status_on, rd_bit;
    logic [AW:0]       rd_addr, ptr;
    logic [WORD_W-1:0] rd_unit;
    prog_kind_e        kind;

    mw_frontend #(.WORD_W(WORD_W), .AW(AW)) u_front (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi), .org(org),
        .prog_busy(prog_busy), .rd_load(rd_load), .rd_shift(rd_shift),
        .rd_addr(rd_addr), .reading(reading), .status_on(status_on),
        .prog_req(prog_req), .prog_kind(kind), .prog_addr(prog_addr),
        .prog_data(prog_data)
    );

    mw_read_shift #(.WORD_W(WORD_W), .AW(AW)) u_shift (
        .clk(clk), .rst_n(rst_n), .org(org), .load(rd_load),
        .load_addr(rd_addr), .shift(rd_shift), .rd_unit(rd_unit),
        .ptr(ptr), .sdo_bit(rd_bit)
    );

    mw_array #(.WORD_W(WORD_W), .WORDS(WORDS)) u_array (
        .clk(clk), .rst_n(rst_n), .org(org), .exec(prog_req), .kind(kind),
        .addr(prog_addr), .wdata(prog_data), .rd_addr(ptr), .rd_unit(rd_unit)
    );

    // Output pin: read bits while streaming, otherwise ready/busy status.
    assign prog_kind = kind;
    assign sdo_oe    = cs & (reading | status_on);
    assign sdo       = reading ? rd_bit : ~prog_busy;

endmodule

// File: tb/mw_cmd_if_test.sv
`timescale 1ns/1ps
module mw_cmd_if_test;
    localparam int WW = 16;
    localparam int NW = 16;
    localparam int AW = 4;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, sdi = 1'b0, org = 1'b1;
    logic prog_busy, sdo, sdo_oe, prog_req;
    logic [1:0] prog_kind;
    logic [AW:0] prog_addr;
    logic [WW-1:0] prog_data;

    int nchk = 0, nfail = 0, busy_cnt = 0, req_cnt = 0;
    logic [1:0] last_kind;
    logic [AW:0] last_addr;
    logic [WW-1:0] last_data;
    logic [15:0] mdl [NW];
    logic q;
    bit done = 0;

    always #2.5 clk = ~clk;

    mw_cmd_if uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi), .org(org),
        .prog_busy(prog_busy), .sdo(sdo), .sdo_oe(sdo_oe), .prog_req(prog_req),
        .prog_kind(prog_kind), .prog_addr(prog_addr), .prog_data(prog_data)
    );

    // Programming controller model: busy for 60 cycles per request.
    assign prog_busy = (busy_cnt != 0);
    always @(posedge clk) begin
        if (prog_req) begin
            busy_cnt  <= 60;
            req_cnt   <= req_cnt + 1;
            last_kind <= prog_kind;
            last_addr <= prog_addr;
            last_data <= prog_data;
        end else if (busy_cnt > 0) begin
            busy_cnt <= busy_cnt - 1;
        end
    end

    typedef struct packed {
        logic        o;
        logic [4:0]  a;
        logic [15:0] d;
    } vec_t;
    localparam vec_t VECS [6] = '{
        '{1'b1, 5'd1,  16'hA5C3},
        '{1'b1, 5'd15, 16'h0F0F},
        '{1'b0, 5'd4,  16'h003C},
        '{1'b0, 5'd5,  16'h0081},
        '{1'b0, 5'd31, 16'h00E7},
        '{1'b1, 5'd0,  16'h8001}
    };

    task automatic check(input string r, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic int alen(input logic o); return o ? 4 : 5; endfunction
    function automatic int dlen(input logic o); return o ? 16 : 8; endfunction

    function automatic logic [15:0] unit_of(input logic o, input int a);
        logic [15:0] w;
        if (o) return mdl[a % 16];
        w = mdl[(a % 32) / 2];
        return ((a % 2) == 0) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    task automatic m_write(input logic o, input int a, input logic [15:0] d);
        if (o) mdl[a] = d;
        else if (a % 2 == 0) mdl[a / 2][15:8] = d[7:0];
        else mdl[a / 2][7:0] = d[7:0];
    endtask

    task automatic pulse(input logic d, output logic qo);
        @(negedge clk) sdi = d;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
        qo = sdo;
        sclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic begin_cmd(input logic o, input int zeros);
        logic qq;
        @(negedge clk) begin org = o; cs = 1'b1; end
        repeat (3) @(negedge clk);
        for (int k = 0; k < zeros; k++) pulse(1'b0, qq);
        pulse(1'b1, qq);
    endtask

    task automatic send(input logic [15:0] v, input int n);
        logic qq;
        for (int k = n - 1; k >= 0; k--) pulse(v[k], qq);
    endtask

    task automatic end_cmd();
        @(negedge clk) begin cs = 1'b0; sdi = 1'b0; end
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_ready();
        while (prog_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_cmd(input logic o, input logic [3:0] opc, input logic [15:0] a,
                          input bit with_data, input logic [15:0] d);
        begin_cmd(o, 1);
        send({12'h000, opc}, 4);
        send(a, alen(o));
        if (with_data) send(d, dlen(o));
        end_cmd();
    endtask

    task automatic read_check(input logic o, input int a, input int n, input int zeros, input string tag);
        logic [15:0] acc;
        logic qq;
        begin_cmd(o, zeros);
        send(16'h0008, 4);
        send(16'(a >> 1), alen(o) - 1);
        pulse(a[0], qq);
        check({tag, " R4 dummy zero"}, {15'h0, qq}, 16'h0000);
        for (int u = 0; u < n; u++) begin
            acc = '0;
            for (int b = 0; b < dlen(o); b++) begin
                pulse(1'b0, qq);
                acc = {acc[14:0], qq};
            end
            check(tag, acc, unit_of(o, a + u));
        end
        end_cmd();
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int prev;
        for (int i = 0; i < NW; i++) mdl[i] = 16'hFFFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11: reset state.
        check("R11 oe low with cs low", {15'h0, sdo_oe}, 16'h0000);
        check("R8 no request after reset", 16'(req_cnt), 16'h0000);
        read_check(1'b1, 3, 1, 0, "R11 erased word after reset");

        // R6: write while latch clear is ignored.
        prev = req_cnt;
        do_cmd(1'b1, 4'b0100, 16'd2, 1'b1, 16'h1234);
        check("R6 no request while latch clear", 16'(req_cnt - prev), 16'h0000);
        read_check(1'b1, 2, 1, 1, "R6 word unchanged");

        // R2: enable opcode.
        do_cmd(1'b1, 4'b0011, 16'd0, 1'b0, 16'h0);

        // Vector table: writes in both organisations, request fields and readback.
        for (int v = 0; v < 6; v++) begin
            prev = req_cnt;
            do_cmd(VECS[v].o, 4'b0100, {11'h0, VECS[v].a}, 1'b1, VECS[v].d);
            check("R8 one request per write", 16'(req_cnt - prev), 16'h0001);
            check("R2 R8 write kind", {14'h0, last_kind}, 16'h0000);
            check("R3 R8 request address", {11'h0, last_addr},
                  VECS[v].o ? {12'h0, VECS[v].a[3:0]} : {11'h0, VECS[v].a});
            check("R8 request data", last_data, VECS[v].o ? VECS[v].d : {8'h00, VECS[v].d[7:0]});
            m_write(VECS[v].o, VECS[v].a, VECS[v].d);
            wait_ready();
            read_check(VECS[v].o, VECS[v].a, 1, 1, "R9 write readback");
        end
        read_check(1'b1, 2, 1, 1, "R3 byte order in word");
        check("R3 word 2 holds bytes 4 and 5", mdl[2], 16'h3C81);

        // R5: sequential read across words and wrap at top address.
        read_check(1'b1, 15, 2, 1, "R5 word wrap stream");
        read_check(1'b0, 30, 3, 1, "R5 byte wrap stream");

        // R1: several leading low clocks before start.
        read_check(1'b1, 1, 1, 4, "R1 leading zeros ignored");

        // R7: chip select drops before the data field is complete.
        prev = req_cnt;
        begin_cmd(1'b1, 1);
        send(16'h0004, 4);
        send(16'd3, 4);
        send(16'h00AA, 8);
        end_cmd();
        check("R7 no request on short write", 16'(req_cnt - prev), 16'h0000);
        read_check(1'b1, 3, 1, 1, "R7 word unchanged");

        // R10: ready/busy status on the output.
        do_cmd(1'b1, 4'b0100, 16'd3, 1'b1, 16'h5555);
        m_write(1'b1, 3, 16'h5555);
        @(negedge clk) cs = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 status driven", {15'h0, sdo_oe}, 16'h0001);
        check("R10 busy reads 0", {15'h0, sdo}, 16'h0000);
        pulse(1'b1, q);
        pulse(1'b0, q);
        check("R10 start ignored while busy oe", {15'h0, sdo_oe}, 16'h0001);
        check("R10 start ignored while busy sdo", {15'h0, sdo}, 16'h0000);
        @(negedge clk) cs = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 oe low after cs falls", {15'h0, sdo_oe}, 16'h0000);
        wait_ready();
        @(negedge clk) cs = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 ready reads 1", {15'h0, sdo}, 16'h0001);
        check("R10 ready oe", {15'h0, sdo_oe}, 16'h0001);
        pulse(1'b1, q);
        check("R10 status ends at start bit", {15'h0, sdo_oe}, 16'h0000);
        end_cmd();

        // R9: erase one byte.
        do_cmd(1'b0, 4'b1100, 16'd6, 1'b0, 16'h0);
        check("R2 R8 erase kind", {14'h0, last_kind}, 16'h0001);
        mdl[3][15:8] = 8'hFF;
        wait_ready();
        read_check(1'b1, 3, 1, 1, "R9 byte erase");

        // R9: erase all.
        do_cmd(1'b1, 4'b0010, 16'd0, 1'b0, 16'h0);
        check("R2 R8 erase-all kind", {14'h0, last_kind}, 16'h0003);
        for (int i = 0; i < NW; i++) mdl[i] = 16'hFFFF;
        wait_ready();
        read_check(1'b1, 1, 1, 1, "R9 erase all");

        // R9: write-all in byte mode then word mode combine by AND.
        do_cmd(1'b0, 4'b0001, 16'd0, 1'b1, 16'h005A);
        check("R2 R8 write-all kind", {14'h0, last_kind}, 16'h0002);
        for (int i = 0; i < NW; i++) mdl[i] = mdl[i] & 16'h5A5A;
        wait_ready();
        do_cmd(1'b1, 4'b0001, 16'd0, 1'b1, 16'hF0FF);
        for (int i = 0; i < NW; i++) mdl[i] = mdl[i] & 16'hF0FF;
        wait_ready();
        check("R9 write-all model", mdl[7], 16'h505A);
        read_check(1'b1, 7, 1, 1, "R9 write-all word");
        read_check(1'b0, 9, 1, 1, "R9 write-all byte");

        // R6: disable, then erase is ignored; read still works.
        do_cmd(1'b1, 4'b0000, 16'd0, 1'b0, 16'h0);
        prev = req_cnt;
        do_cmd(1'b1, 4'b1100, 16'd7, 1'b0, 16'h0);
        check("R6 no request after disable", 16'(req_cnt - prev), 16'h0000);
        read_check(1'b1, 7, 1, 1, "R6 read after disable");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule